// File: doc/BRIEF.md
# Debounced Input Interrupt Bank

This block takes eight raw external lines, brings each into the core clock domain, and filters it with a debounce counter that advances on a millisecond tick. A channel's filtered level changes only after the synchronised input has held a new value for a programmed number of ticks. Each channel sets its own tick count, from 1 to 4095.

The filtered levels drive level-sensitive interrupts. For each channel, software chooses whether a high or a low filtered level is the active one. An interrupt latches only when the channel is enabled and its one-shot arm bit is set. Latching clears the arm bit in hardware, so software must re-arm the channel after acknowledging it. The pending bits ANDed with the enables form the masked status, and their OR drives a single interrupt line.

Software reaches the block through a plain 32-bit register port with a combinational read. There is no back-pressure: every write completes in the cycle it is presented, and read data is valid in the same cycle as the address.

Register offsets:

| Offset | Register |
|---|---|
| 0x00 | filtered data (gated by the read mask) |
| 0x04 | data read mask |
| 0x14 | polarity |
| 0x18 | enable |
| 0x1C | raw pending status |
| 0x20 | masked status |
| 0x24 | clear |
| 0x28 | arm |
| 0x40 + 4·n | control word for channel n |

Top module: `dbounce_irq_bank`

## Requirements
- R1: After reset, every register at offsets 0x00, 0x04, 0x14, 0x18, 0x1C, 0x20 and 0x28 reads 0. Each control word at 0x40+4·n reads 1, and irq_out is 0.
- R2: A read of offset 0x00 returns the filtered levels ANDed with the read mask at 0x04, in bits [7:0]. Bit n belongs to channel n.
- R3: A filtered level takes a new input value on the Nth millisecond tick during which the synchronised input has differed from it, where N is the channel's programmed count. If the input returns to the filtered value before then, the count restarts from zero.
- R4: The control word at 0x40+4·n keeps bits [11:0] as the debounce count and reads 0 in bits [31:12]. A count of 0 behaves as 1.
- R5: Polarity bit n at 0x14 selects the active filtered level of channel n: 1 means high, 0 means low.
- R6: A pending bit at 0x1C is set only when the channel's filtered level is active, its enable bit at 0x18 is 1, and its arm bit at 0x28 is 1. Latching clears that arm bit. A software write to 0x28 in the same cycle takes priority over that clear.
- R7: Writing to 0x24 clears each pending bit whose data bit is 1 and leaves the others as they are. Writes to the status offsets 0x1C and 0x20 are ignored.
- R8: The masked status at 0x20 equals the pending bits ANDed with the enables, and irq_out is high exactly when any masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_addr | input | 8 | register byte offset |
| reg_we | input | 1 | write strobe |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| pin_in | input | 8 | raw external lines, asynchronous |
| ms_tick | input | 1 | one-cycle pulse each millisecond |
| irq_out | output | 1 | combined interrupt |

## Verification
A debounce counter in the wrong state shows up as the data register changing one tick early or late, so the bench reads the data register just before and just after the Nth tick. A stale arm or pending flop shows up as a second latch after acknowledge, or as a missing latch, and irq_out reflects it one cycle after the arm write. Sweeping every channel across both polarities and both enable settings makes any cross-channel bit mix-up visible in the per-bit status read.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int CNT_W    = 12;
  localparam logic [AW-1:0] OFS_DATA = 8'h00;
  localparam logic [AW-1:0] OFS_DMSK = 8'h04;
  localparam logic [AW-1:0] OFS_POL  = 8'h14;
  localparam logic [AW-1:0] OFS_EN   = 8'h18;
  localparam logic [AW-1:0] OFS_RAW  = 8'h1C;
  localparam logic [AW-1:0] OFS_MSK  = 8'h20;
  localparam logic [AW-1:0] OFS_CLR  = 8'h24;
  localparam logic [AW-1:0] OFS_ARM  = 8'h28;
  localparam logic [AW-1:0] OFS_CTL  = 8'h40;
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dbi_filter.sv
module dbi_filter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             din,
  input  logic [CNT_W-1:0] limit,
  output logic             level
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // a programmed zero acts as one tick
  assign last = (limit == '0) ? '0 : limit - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (din == level) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= last) begin
        level <= din;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbi_irq_ctrl.sv
module dbi_irq_ctrl #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] level,
  input  logic [NCH-1:0] pol,
  input  logic [NCH-1:0] en,
  input  logic           arm_we,
  input  logic [NCH-1:0] arm_wdata,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] arm,
  output logic [NCH-1:0] masked,
  output logic           irq
);
  logic [NCH-1:0] active;
  logic [NCH-1:0] fire;

  assign active = ~(level ^ pol);
  assign fire   = active & en & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      arm <= '0;
    end else begin
      raw <= (raw & ~clr) | fire;
      if (arm_we) arm <= arm_wdata;
      else        arm <= arm & ~fire;
    end
  end

  assign masked = raw & en;
  assign irq    = |masked;
endmodule

// File: rtl/dbounce_irq_bank.sv
module dbounce_irq_bank
  import dbi_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NCH-1:0] pin_in,
  input  logic          ms_tick,
  output logic          irq_out
);
  localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PAD    = DW - NCH;
  localparam int CTL_END = OFS_CTL + 4 * NCH;

  logic [NCH-1:0] synced, filt;
  logic [NCH-1:0] dmask_q, pol_q, en_q;
  logic [NCH-1:0] raw_q, arm_q, masked;
  logic [CNT_W-1:0] ctrl_q [NCH];
  logic [AW-1:0]  ctl_off;
  logic [IDX_W-1:0] ctl_idx;
  logic           ctl_hit;
  logic [NCH-1:0] clr_mask;
  logic           arm_we;
  logic           unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DW-1:CNT_W];

  dbi_sync #(.W(NCH)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin_in), .q(synced));

  assign ctl_off = reg_addr - OFS_CTL;
  assign ctl_idx = ctl_off[2 +: IDX_W];
  assign ctl_hit = (int'(reg_addr) >= int'(OFS_CTL)) && (int'(reg_addr) < CTL_END)
                   && (reg_addr[1:0] == 2'b00);

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic wr_ctl;
      assign wr_ctl = reg_we && ctl_hit && (ctl_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q[i] <= CNT_W'(1);
        else if (wr_ctl) ctrl_q[i] <= reg_wdata[CNT_W-1:0];
      end
      dbi_filter #(.CNT_W(CNT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick), .din(synced[i]),
        .limit(ctrl_q[i]), .level(filt[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_DMSK: dmask_q <= reg_wdata[NCH-1:0];
        OFS_POL:  pol_q   <= reg_wdata[NCH-1:0];
        OFS_EN:   en_q    <= reg_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  assign arm_we   = reg_we && (reg_addr == OFS_ARM);
  assign clr_mask = (reg_we && (reg_addr == OFS_CLR)) ? reg_wdata[NCH-1:0] : '0;

  dbi_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .level(filt), .pol(pol_q), .en(en_q),
    .arm_we(arm_we), .arm_wdata(reg_wdata[NCH-1:0]), .clr(clr_mask),
    .raw(raw_q), .arm(arm_q), .masked(masked), .irq(irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (ctl_hit) begin
      reg_rdata = {{(DW-CNT_W){1'b0}}, ctrl_q[ctl_idx]};
    end else begin
      case (reg_addr)
        OFS_DATA: reg_rdata = {{PAD{1'b0}}, filt & dmask_q};
        OFS_DMSK: reg_rdata = {{PAD{1'b0}}, dmask_q};
        OFS_POL:  reg_rdata = {{PAD{1'b0}}, pol_q};
        OFS_EN:   reg_rdata = {{PAD{1'b0}}, en_q};
        OFS_RAW:  reg_rdata = {{PAD{1'b0}}, raw_q};
        OFS_MSK:  reg_rdata = {{PAD{1'b0}}, masked};
        OFS_ARM:  reg_rdata = {{PAD{1'b0}}, arm_q};
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbi_checker.sv
module dbi_checker
  import dbi_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  reg_addr,
  input logic           reg_we,
  input logic [DW-1:0]  reg_wdata,
  input logic           ms_tick,
  input logic           irq_out,
  input logic [NCH-1:0] raw,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] arm,
  input logic [NCH-1:0] filt
);
  logic           wr_arm;
  logic [NCH-1:0] clr_bits;
  assign wr_arm   = reg_we && (reg_addr == OFS_ARM);
  assign clr_bits = (reg_we && (reg_addr == OFS_CLR)) ? reg_wdata[NCH-1:0] : '0;

  // R3
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> $past(ms_tick));
  // R6
  latch_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & ~$past(raw) & ~$past(arm & en)) == '0);
  // R6
  arm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_arm) |-> ((raw & ~$past(raw) & arm) == '0));
  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~raw & $past(raw) & ~$past(clr_bits)) == '0);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !irq_out);
  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((raw & en) != '0));
endmodule

bind dbounce_irq_bank dbi_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .ms_tick(ms_tick), .irq_out(irq_out),
  .raw(raw_q), .en(en_q), .arm(arm_q), .filt(filt)
);

// File: tb/dbounce_irq_bank_test.sv
module dbounce_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam logic [7:0] A_DATA = 8'h00, A_DMSK = 8'h04, A_POL = 8'h14, A_EN = 8'h18,
                         A_RAW = 8'h1C, A_MSK = 8'h20, A_CLR = 8'h24, A_ARM = 8'h28,
                         A_CTL = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] pin_in = '0;
  logic ms_tick = 1'b0;
  logic irq_out;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbounce_irq_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .ms_tick(ms_tick), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_DATA, d); chk("R1 data", d, 0);
    rd(A_DMSK, d); chk("R1 dmask", d, 0);
    rd(A_POL, d);  chk("R1 pol", d, 0);
    rd(A_EN, d);   chk("R1 en", d, 0);
    rd(A_RAW, d);  chk("R1 raw", d, 0);
    rd(A_MSK, d);  chk("R1 masked", d, 0);
    rd(A_ARM, d);  chk("R1 arm", d, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(A_CTL + 8'(4*c), d); chk("R1 ctrl", d, 1);
    end

    // R4 field width and zero count
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, d); chk("R4 upper bits", d, 32'hFFF);
    wr(A_CTL, 32'h0);         rd(A_CTL, d); chk("R4 zero", d, 0);
    wr(A_DMSK, 32'hFF);
    pin_in[0] = 1'b1; settle(); ticks(1);
    rd(A_DATA, d); chk("R4 zero acts as one", d & 1, 1);
    pin_in[0] = 1'b0; settle(); ticks(1);

    // R3 debounce sweep, channel c uses c+1 ticks
    for (int c = 0; c < NCH; c++) wr(A_CTL + 8'(4*c), 32'(c + 1));
    for (int c = 0; c < NCH; c++) begin
      pin_in[c] = 1'b1; settle(); ticks(c);
      rd(A_DATA, d); chk("R3 early", (d >> c) & 1, 0);
      ticks(1);
      rd(A_DATA, d); chk("R3 on count", (d >> c) & 1, 1);
      pin_in[c] = 1'b0; settle(); ticks(c);
      pin_in[c] = 1'b1; settle();
      pin_in[c] = 1'b0; settle(); ticks(c);
      rd(A_DATA, d); chk("R3 restart", (d >> c) & 1, 1);
      ticks(1);
      rd(A_DATA, d); chk("R3 fall", (d >> c) & 1, 0);
    end

    // R2 read mask gating
    pin_in = '1; settle(); ticks(NCH);
    wr(A_DMSK, 32'h5A); rd(A_DATA, d); chk("R2 mask 5A", d, 32'h5A);
    wr(A_DMSK, 32'hFF); rd(A_DATA, d); chk("R2 mask FF", d, 32'hFF);
    pin_in = '0; settle(); ticks(NCH);
    rd(A_DATA, d); chk("R2 low", d, 0);
    for (int c = 0; c < NCH; c++) wr(A_CTL + 8'(4*c), 32'd1);

    // R5 R6 R7 R8 sweep over channel, polarity, enable
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int e = 0; e < 2; e++) begin
          v = 32'(1) << c;
          wr(A_POL, p ? v : 0);
          wr(A_EN, e ? v : 0);
          wr(A_CLR, 32'hFF);
          pin_in = p ? NCH'(v) : '0; settle(); ticks(1);
          wr(A_ARM, v);
          rd(A_RAW, d); chk("R6 latch", d, e ? v : 0);
          rd(A_MSK, d); chk("R8 masked", d, e ? v : 0);
          chk("R8 irq", {31'b0, irq_out}, 32'(e));
          rd(A_ARM, d); chk("R6 arm", d, e ? 0 : v);
          wr(A_CLR, v);
          rd(A_RAW, d); chk("R7 clear", d, 0);
          chk("R7 irq low", {31'b0, irq_out}, 0);
          wr(A_POL, p ? 0 : v);
          wr(A_ARM, v);
          rd(A_RAW, d); chk("R5 inactive level", d, 0);
          wr(A_ARM, 0);
          pin_in = '0; settle(); ticks(1);
        end
      end
    end

    // R7 partial clear and ignored status writes
    wr(A_POL, 32'h3); wr(A_EN, 32'h3); wr(A_CLR, 32'hFF);
    pin_in = 8'h03; settle(); ticks(1);
    wr(A_ARM, 32'h3);
    rd(A_RAW, d); chk("R6 two", d, 3);
    wr(A_CLR, 32'h1);
    rd(A_RAW, d); chk("R7 partial", d, 2);
    chk("R8 irq held", {31'b0, irq_out}, 1);
    wr(A_RAW, 32'hFF); wr(A_MSK, 32'h0);
    rd(A_RAW, d); chk("R7 ro raw", d, 2);
    wr(A_EN, 32'h1);
    rd(A_MSK, d); chk("R8 masked off", d, 0);
    chk("R8 irq off", {31'b0, irq_out}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule